// File: doc/BRIEF.md
# Shared FIR Coefficient Memory Loader

This block sits on the register side of a three-stage decimating FIR chain. All three filters draw their taps from a single coefficient memory. Software loads that memory through a narrow register window. It first sets a write pointer. It then streams coefficients one word per write, and the pointer steps forward after each one. Three control words, one per filter, hold the tap count, the decimation ratio, the rounding mode and an enable bit. These values are presented to the filter engines as outputs.

The block places the three filters' regions back to back in memory. Filter 0 starts at address 0. Each later filter starts where the one before it ends, so its base is the running sum of the tap counts before it. The filter engines fetch a coefficient by giving a filter index and a tap number. The coefficient comes back one clock later. Any tap outside the filter's programmed region reads as zero.

Top module: `coef_loader`

## Requirements
- R1: After reset the tap counts are 87, 33 and 119, every decimation ratio is 2, the rounding modes are 1, 0 and 1, all enables are 0, and the overflow flag is 0.
- R2: A write to offset 0x08, 0x0C or 0x10 updates the control word of filter 0, 1 or 2. Tap count is taken from bits [8:0], decimation ratio from bits [15:12], rounding mode from bits [17:16] and enable from bit 31. All other bits are ignored.
- R3: A write to offset 0x00 loads the write pointer from bits [8:0] of the data. Value 0 addresses the first memory word.
- R4: A write to offset 0x04 stores bits [23:0] at the pointer and then increments the pointer. Bits [31:24] are ignored.
- R5: The base of filter 0 is 0. The base of filter 1 equals filter 0's tap count. The base of filter 2 equals the sum of the first two tap counts.
- R6: A read request returns, on the next cycle, rd_valid high and the word stored at base(filter) + tap.
- R7: A read whose tap is at or above the filter's tap count, or whose filter index is 3, returns zero.
- R8: A data write while the pointer is at or past the memory depth (336) is dropped. The pointer does not move, and a sticky overflow flag is set that only reset clears.
- R9: A read whose address base + tap reaches or passes the memory depth returns zero.
- R10: Writes to any other offset change neither the control words, the pointer nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| rd_req | input | 1 | Coefficient fetch request |
| rd_filt | input | 2 | Filter index of the fetch |
| rd_tap | input | 9 | Tap number within the filter |
| rd_valid | output | 1 | Fetch result valid, one cycle after rd_req |
| rd_data | output | 24 | Fetched coefficient, or zero when out of range |
| flt_taps | output | 27 | Tap count of each filter, 9 bits per filter |
| flt_decim | output | 12 | Decimation ratio of each filter, 4 bits per filter |
| flt_round | output | 6 | Rounding mode of each filter, 2 bits per filter |
| flt_en | output | 3 | Enable bit of each filter |
| flt_base | output | 36 | Base address of each filter, 12 bits per filter |
| overflow | output | 1 | Sticky flag for a dropped data write |

## Verification
The embedded properties check several rules on every clock: the one-cycle fetch latency, the pointer step after an accepted data write, the dropped write with its held pointer and set flag, the stickiness of the overflow flag, and the zero result for fetches past a tap count. Other behaviour can only be shown by the directed scenarios, because it depends on what was written earlier. That covers the reset defaults, the field decoding of the control words, back-to-back base placement after a tap count changes, and the data returned for a given address. It also covers the masking of the upper data byte, the zero result past the end of memory, and the fact that unmapped writes disturb nothing.

// File: rtl/coef_loader.sv
module coef_loader #(
  parameter int DEPTH = 336,
  parameter int NFILT = 3,
  parameter int CW    = 24,
  parameter int TW    = 9,
  parameter int DW    = 4,
  parameter int RW    = 2,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int FIW  = $clog2(NFILT + 1),
  localparam int SW   = TW + FIW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 rd_req,
  input  logic [FIW-1:0]       rd_filt,
  input  logic [TW-1:0]        rd_tap,
  output logic                 rd_valid,
  output logic [CW-1:0]        rd_data,
  output logic [NFILT*TW-1:0]  flt_taps,
  output logic [NFILT*DW-1:0]  flt_decim,
  output logic [NFILT*RW-1:0]  flt_round,
  output logic [NFILT-1:0]     flt_en,
  output logic [NFILT*SW-1:0]  flt_base,
  output logic                 overflow
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);

  function automatic logic [TW-1:0] init_taps(int i);
    case (i)
      0:       return TW'(87);
      1:       return TW'(33);
      default: return TW'(119);
    endcase
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;

  wire ptr_wr  = bus_we && bus_addr == 8'h00;
  wire dat_wr  = bus_we && bus_addr == 8'h04;
  wire room    = ptr < DEPTH_P;
  wire store   = dat_wr && room;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ptr <= '0;
    else if (ptr_wr) ptr <= bus_wdata[PW-1:0];
    else if (store)  ptr <= ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                overflow <= 1'b0;
    else if (dat_wr && !room)  overflow <= 1'b1;

  always_ff @(posedge clk)
    if (store) mem[ptr] <= bus_wdata[CW-1:0];

  for (genvar g = 0; g < NFILT; g++) begin : g_ctl
    wire hit = bus_we && bus_addr == 8'(8 + 4 * g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        flt_taps [g*TW +: TW] <= init_taps(g);
        flt_decim[g*DW +: DW] <= DW'(2);
        flt_round[g*RW +: RW] <= (g == 1) ? RW'(0) : RW'(1);
        flt_en[g]             <= 1'b0;
      end else if (hit) begin
        flt_taps [g*TW +: TW] <= bus_wdata[8:0];
        flt_decim[g*DW +: DW] <= bus_wdata[15:12];
        flt_round[g*RW +: RW] <= bus_wdata[17:16];
        flt_en[g]             <= bus_wdata[31];
      end
  end

  always_comb begin
    flt_base[SW-1:0] = '0;
    for (int i = 1; i < NFILT; i++)
      flt_base[i*SW +: SW] = flt_base[(i-1)*SW +: SW] + SW'(flt_taps[(i-1)*TW +: TW]);
  end

  logic [TW-1:0] sel_taps;
  logic [SW-1:0] sel_base;
  always_comb begin
    sel_taps = '0;
    sel_base = '0;
    for (int i = 0; i < NFILT; i++)
      if (rd_filt == FIW'(i)) begin
        sel_taps = flt_taps[i*TW +: TW];
        sel_base = flt_base[i*SW +: SW];
      end
  end

  wire [SW-1:0] raddr  = sel_base + SW'(rd_tap);
  wire          in_rng = rd_tap < sel_taps && raddr < DEPTH_S;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= in_rng ? mem[raddr[PW-1:0]] : '0;
    end

  p_fetch_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && room) |=> ptr == $past(ptr) + 1'b1);

  p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !room) |=> overflow && $stable(ptr));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_beyond_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_tap >= sel_taps) |=> rd_data == '0);

endmodule

// File: tb/coef_loader_tb.sv
`timescale 1ns/1ps
module coef_loader_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        rd_req = 0;
  logic [1:0]  rd_filt = 0;
  logic [8:0]  rd_tap = 0;
  logic        rd_valid, overflow;
  logic [23:0] rd_data;
  logic [26:0] flt_taps;
  logic [11:0] flt_decim;
  logic [5:0]  flt_round;
  logic [2:0]  flt_en;
  logic [35:0] flt_base;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  coef_loader u_dut (.*);

  function automatic logic [23:0] coef(int i);
    return 24'(i * 24'h01F3A7 + 24'h000135);
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [1:0] f, logic [8:0] t, output logic [23:0] v);
    @(negedge clk); rd_req = 1; rd_filt = f; rd_tap = t;
    @(negedge clk); rd_req = 0;
    chk("R6 valid", rd_valid, 1);
    v = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 taps", flt_taps, {9'd119, 9'd33, 9'd87});
    chk("R1 decim", flt_decim, 12'h222);
    chk("R1 round", flt_round, 6'b01_00_01);
    chk("R1 en", flt_en, 0);
    chk("R1 overflow", overflow, 0);
    chk("R5 base", flt_base, {12'd120, 12'd87, 12'd0});
  endtask

  task automatic t_load;
    logic [23:0] v;
    wr(8'h00, 0);
    for (int i = 0; i < 239; i++) wr(8'h04, {8'hC3, coef(i)});
    rd(0, 0, v);   chk("R4 f0 t0", v, coef(0));
    rd(0, 86, v);  chk("R6 f0 t86", v, coef(86));
    rd(1, 0, v);   chk("R6 f1 t0", v, coef(87));
    rd(2, 118, v); chk("R6 f2 t118", v, coef(238));
  endtask

  task automatic t_beyond;
    logic [23:0] v;
    rd(0, 87, v);  chk("R7 f0 t87", v, 0);
    rd(1, 200, v); chk("R7 f1 t200", v, 0);
    rd(3, 0, v);   chk("R7 filter3", v, 0);
  endtask

  task automatic t_ctrl;
    logic [23:0] v;
    wr(8'h0C, 32'h8000_0000 | (3 << 16) | (5 << 12) | 10 | 32'h0FF0_0E00);
    chk("R2 taps", flt_taps[17:9], 10);
    chk("R2 decim", flt_decim[7:4], 5);
    chk("R2 round", flt_round[3:2], 3);
    chk("R2 en", flt_en, 3'b010);
    chk("R5 base2", flt_base[35:24], 97);
    rd(2, 0, v); chk("R5 f2 t0", v, coef(97));
  endtask

  task automatic t_pointer;
    logic [23:0] v;
    wr(8'h10, 300 | (2 << 12) | (1 << 16));
    wr(8'h00, 300);
    wr(8'h04, 32'hFF5A_5A5A);
    rd(2, 203, v); chk("R3 ptr300", v, 24'h5A5A5A);
    rd(2, 250, v); chk("R9 past depth", v, 0);
  endtask

  task automatic t_overflow;
    logic [23:0] v;
    wr(8'h00, 335);
    wr(8'h04, 32'h0012_3456);
    chk("R8 no ovf yet", overflow, 0);
    wr(8'h04, 32'h00AB_CDEF);
    chk("R8 ovf set", overflow, 1);
    wr(8'h04, 32'h0011_1111);
    rd(2, 238, v); chk("R8 last kept", v, 24'h123456);
    wr(8'h00, 0);
    chk("R8 sticky", overflow, 1);
    wr(8'h04, 32'h0077_0077);
    rd(0, 0, v); chk("R8 ptr reload", v, 24'h770077);
  endtask

  task automatic t_unmapped;
    logic [23:0] v;
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_0000);
    wr(8'h02, 32'h0000_0100);
    chk("R10 taps", flt_taps[8:0], 87);
    chk("R10 en", flt_en, 3'b010);
    wr(8'h04, 32'h0000_BEEF);
    rd(0, 1, v); chk("R10 ptr", v, 24'h00BEEF);
    rd(0, 2, v); chk("R10 mem", v, coef(2));
  endtask

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_load;
    t_beyond;
    t_ctrl;
    t_pointer;
    t_overflow;
    t_unmapped;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule